// File: doc/BRIEF.md
# Host-Side Link Synchronization and Auto-Poll Controller

This block runs the host end of a two-way framed link across an isolation barrier. Decoded upstream frames come in with a type, a payload nibble and a valid strobe. The block sends idle frames downstream until the far end shows it is alive by sending a status frame. At that point the host treats the upstream direction as synchronized.

If automatic polling is enabled when synchronization is reached, the block sends exactly one identifier-poll frame and then switches to transmit-data frames. The far end answers with a reply frame. The block latches the reply's nibble into a readable revision field. Software reads that field through a small register read port. A nonzero value shows that both link directions work.

Loss of the link clears the sync flag and the revision field. A later status frame starts a new synchronization episode, and that episode issues a new poll.

Top module: `link_autopoll_ctrl`

## Requirements
- R1: During and right after reset, `syncFlag` is 0, `dnType` is 00, `dnPayload` is 0, `revField` is 0 and a read of the revision register returns 0.
- R2: While unsynchronized, every downstream frame is idle: `dnType` is 00 and `dnPayload` is 0.
- R3: An upstream frame with `upValid`=1 and `upType`=01 (status) seen while unsynchronized, with `linkLost` low, sets `syncFlag` at the next clock edge. Upstream types 00 (none), 10 (identifier reply) and 11 (receive data) never cause synchronization.
- R4: If `pollEnable` is 1 when the status frame is taken, the first synchronized cycle sends `dnType`=01 with `dnPayload`=`POLL_CODE`. Every later synchronized cycle sends `dnType`=10 with `dnPayload` equal to `txData`.
- R5: If `pollEnable` is 0 when the status frame is taken, no poll is sent. Transmit-data frames (`dnType`=10) start in the first synchronized cycle, and `revField` stays 0 for the whole episode.
- R6: The first reply frame (`upType`=10) taken after the poll frame has been sent loads `upPayload` into `revField` at the next edge. A far end that answers 1100 makes the field read 1100.
- R7: Reply frames that arrive before the poll has been sent, or after the field has been loaded, are ignored, and so is any receive-data frame.
- R8: At most one poll frame is sent per synchronization episode. Further status frames while synchronized do not cause another poll.
- R9: `linkLost`=1 makes `syncFlag` 0, `revField` 0 and the downstream frames idle at the next edge. It takes precedence over a status frame in the same cycle.
- R10: After a loss of the link, a new status frame starts a new episode, which sends a new poll if `pollEnable` is 1.
- R11: `rdData` is combinational. At `rdAddr`=`REV_ADDR` (default 0x1D) it returns `revField` in bits [7:4] and zeros in bits [3:0]. At any other address it returns 0.
- R12: `pollEnable` is sampled only when the status frame is taken. Changing it later in the episode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upValid | input | 1 | Upstream frame strobe |
| upType | input | 2 | Upstream frame type: 00 none, 01 status, 10 identifier reply, 11 receive data |
| upPayload | input | REV_W | Upstream frame payload nibble |
| linkLost | input | 1 | Link-loss indication |
| pollEnable | input | 1 | Auto-poll enable control bit |
| txData | input | DATA_W | Payload for transmit-data frames |
| dnType | output | 2 | Downstream frame type: 00 idle, 01 identifier poll, 10 transmit data |
| dnPayload | output | DATA_W | Downstream frame payload |
| syncFlag | output | 1 | Upstream direction synchronized |
| revField | output | REV_W | Latched far-end revision |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | REG_W | Register read data |

## Verification
On every cycle, the assertions check the following:
- an unsynchronized link sends only idle frames and holds a zero revision field;
- link loss clears the flag and the field;
- a status frame synchronizes the link;
- a poll is always followed by data;
- no episode sends more than one poll;
- the revision field changes only on a reply or a clear.

The bench's scenarios are needed for the rest:
- the field takes the first reply's value;
- early and late replies are ignored;
- the enable bit is sampled only at synchronization;
- a resync issues a fresh poll;
- loss takes precedence over a simultaneous status frame.

All of these depend on a specific order of stimulus.

// File: rtl/link_autopoll_pkg.sv
package link_autopoll_pkg;

  typedef enum logic [1:0] {
    DN_IDLE = 2'b00,
    DN_POLL = 2'b01,
    DN_DATA = 2'b10
  } dnFrame_e;

  typedef enum logic [1:0] {
    UP_NONE   = 2'b00,
    UP_STATUS = 2'b01,
    UP_REPLY  = 2'b10,
    UP_RXDATA = 2'b11
  } upFrame_e;

  typedef enum logic [1:0] {
    ST_UNSYNC = 2'b00,
    ST_POLL   = 2'b01,
    ST_DATA   = 2'b10
  } linkState_e;

  typedef struct packed {
    dnFrame_e dnSel;
    logic     clearRev;
    logic     latchRev;
  } ctlStrobe_t;

endpackage

// File: rtl/link_autopoll_fsm.sv
module link_autopoll_fsm
  import link_autopoll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upValid,
  input  logic [1:0] upType,
  input  logic       linkLost,
  input  logic       pollEnable,
  output ctlStrobe_t ctl,
  output logic       syncFlag
);

  linkState_e state, stateNext;
  logic       pending, pendingNext;
  logic       statusSeen, replySeen;

  assign statusSeen = upValid && (upType == UP_STATUS);
  assign replySeen  = upValid && (upType == UP_REPLY);

  // Next-state logic: loss has priority; the enable bit is sampled only on sync entry
  always_comb begin
    stateNext   = state;
    pendingNext = pending;
    if (linkLost) begin
      stateNext   = ST_UNSYNC;
      pendingNext = 1'b0;
    end else begin
      unique case (state)
        ST_UNSYNC: begin
          pendingNext = 1'b0;
          if (statusSeen) stateNext = pollEnable ? ST_POLL : ST_DATA;
        end
        ST_POLL: begin
          stateNext   = ST_DATA;
          pendingNext = 1'b1;
        end
        ST_DATA: begin
          if (pending && replySeen) pendingNext = 1'b0;
        end
        default: begin
          stateNext   = ST_UNSYNC;
          pendingNext = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_UNSYNC;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendingNext;
    end
  end

  // Strobes toward the datapath
  always_comb begin
    unique case (state)
      ST_POLL: ctl.dnSel = DN_POLL;
      ST_DATA: ctl.dnSel = DN_DATA;
      default: ctl.dnSel = DN_IDLE;
    endcase
    ctl.clearRev = linkLost || (state == ST_UNSYNC);
    ctl.latchRev = !linkLost && (state == ST_DATA) && pending && replySeen;
  end

  assign syncFlag = (state != ST_UNSYNC);

endmodule

// File: rtl/link_autopoll_dp.sv
module link_autopoll_dp
  import link_autopoll_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REV_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned REV_LSB   = 4,
  parameter logic [ADDR_W-1:0] REV_ADDR  = 8'h1D,
  parameter logic [DATA_W-1:0] POLL_CODE = 8'hD1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [REV_W-1:0]  upPayload,
  input  logic [DATA_W-1:0] txData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [1:0]        dnType,
  output logic [DATA_W-1:0] dnPayload,
  output logic [REV_W-1:0]  revField,
  output logic [REG_W-1:0]  rdData
);

  localparam int unsigned REV_MSB = REV_LSB + REV_W - 1;

  logic [REV_W-1:0] revReg;
  logic             addrHit;

  // Revision holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            revReg <= '0;
    else if (ctl.clearRev) revReg <= '0;
    else if (ctl.latchRev) revReg <= upPayload;
  end

  assign revField = revReg;

  // Downstream frame selection
  always_comb begin
    dnType = ctl.dnSel;
    unique case (ctl.dnSel)
      DN_POLL: dnPayload = POLL_CODE;
      DN_DATA: dnPayload = txData;
      default: dnPayload = '0;
    endcase
  end

  // Read port: revision placed at REV_LSB of the register word
  assign addrHit = (rdAddr == REV_ADDR);

  for (genvar b = 0; b < REG_W; b++) begin : g_rdBit
    if (b >= REV_LSB && b <= REV_MSB) begin : g_fld
      assign rdData[b] = addrHit & revReg[b - REV_LSB];
    end else begin : g_zero
      assign rdData[b] = 1'b0;
    end
  end

endmodule

// File: rtl/link_autopoll_ctrl.sv
module link_autopoll_ctrl
  import link_autopoll_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REV_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned REV_LSB   = 4,
  parameter logic [ADDR_W-1:0] REV_ADDR  = 8'h1D,
  parameter logic [DATA_W-1:0] POLL_CODE = 8'hD1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upValid,
  input  logic [1:0]        upType,
  input  logic [REV_W-1:0]  upPayload,
  input  logic              linkLost,
  input  logic              pollEnable,
  input  logic [DATA_W-1:0] txData,
  output logic [1:0]        dnType,
  output logic [DATA_W-1:0] dnPayload,
  output logic              syncFlag,
  output logic [REV_W-1:0]  revField,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData
);

  ctlStrobe_t ctl;

  link_autopoll_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .upValid    (upValid),
    .upType     (upType),
    .linkLost   (linkLost),
    .pollEnable (pollEnable),
    .ctl        (ctl),
    .syncFlag   (syncFlag)
  );

  link_autopoll_dp #(
    .DATA_W    (DATA_W),
    .REV_W     (REV_W),
    .ADDR_W    (ADDR_W),
    .REG_W     (REG_W),
    .REV_LSB   (REV_LSB),
    .REV_ADDR  (REV_ADDR),
    .POLL_CODE (POLL_CODE)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .upPayload (upPayload),
    .txData    (txData),
    .rdAddr    (rdAddr),
    .dnType    (dnType),
    .dnPayload (dnPayload),
    .revField  (revField),
    .rdData    (rdData)
  );

endmodule

// File: rtl/link_autopoll_chk.sv
module link_autopoll_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REV_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned REV_LSB   = 4,
  parameter logic [ADDR_W-1:0] REV_ADDR = 8'h1D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upValid,
  input logic [1:0]        upType,
  input logic              linkLost,
  input logic [1:0]        dnType,
  input logic [DATA_W-1:0] dnPayload,
  input logic              syncFlag,
  input logic [REV_W-1:0]  revField,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [REG_W-1:0]  rdData
);

  logic [1:0] pollCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              pollCount <= '0;
    else if (!syncFlag)                      pollCount <= '0;
    else if (dnType == 2'b01 && pollCount != 2'd3) pollCount <= pollCount + 2'd1;
  end

  // R9
  lost_clears_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkLost |=> !syncFlag);

  // R9
  lost_clears_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linkLost |=> (revField == '0));

  // R2
  idle_when_unsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !syncFlag |-> (dnType == 2'b00 && dnPayload == '0));

  // R5
  rev_zero_unsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !syncFlag |-> (revField == '0));

  // R3
  status_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!syncFlag && upValid && upType == 2'b01 && !linkLost) |=> syncFlag);

  // R4
  poll_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dnType == 2'b01 && !linkLost) |=> (dnType == 2'b10));

  // R8
  single_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pollCount <= 2'd1);

  // R7
  rev_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(revField) |-> (revField == '0 || $past(upValid && upType == 2'b10)));

  // R11
  read_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == REV_ADDR) |-> (rdData[REV_LSB +: REV_W] == revField));

endmodule

bind link_autopoll_ctrl link_autopoll_chk #(
  .DATA_W   (DATA_W),
  .REV_W    (REV_W),
  .ADDR_W   (ADDR_W),
  .REG_W    (REG_W),
  .REV_LSB  (REV_LSB),
  .REV_ADDR (REV_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upValid   (upValid),
  .upType    (upType),
  .linkLost  (linkLost),
  .dnType    (dnType),
  .dnPayload (dnPayload),
  .syncFlag  (syncFlag),
  .revField  (revField),
  .rdAddr    (rdAddr),
  .rdData    (rdData)
);

// File: tb/link_autopoll_ctrl_tb.sv
module link_autopoll_ctrl_tb;

  localparam logic [7:0] POLL_CODE = 8'hD1;
  localparam logic [7:0] REV_ADDR  = 8'h1D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upValid = 1'b0;
  logic [1:0] upType = 2'b00;
  logic [3:0] upPayload = 4'h0;
  logic       linkLost = 1'b0;
  logic       pollEnable = 1'b0;
  logic [7:0] txData = 8'h00;
  logic [7:0] rdAddr = 8'h00;
  logic [1:0] dnType;
  logic [7:0] dnPayload;
  logic       syncFlag;
  logic [3:0] revField;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // Behavioural reference state
  bit       mSync = 0;
  bit       mPollNow = 0;
  bit       mAwait = 0;
  int       mRev = 0;

  always #4 clk = ~clk;

  link_autopoll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .upValid(upValid), .upType(upType),
    .upPayload(upPayload), .linkLost(linkLost), .pollEnable(pollEnable),
    .txData(txData), .dnType(dnType), .dnPayload(dnPayload),
    .syncFlag(syncFlag), .revField(revField), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    if (!rst_n) begin
      mSync = 0; mPollNow = 0; mAwait = 0; mRev = 0;
    end else if (linkLost) begin
      mSync = 0; mPollNow = 0; mAwait = 0; mRev = 0;
    end else if (!mSync) begin
      if (upValid && upType == 2'b01) begin
        mSync = 1;
        mPollNow = pollEnable;
      end
    end else if (mPollNow) begin
      mPollNow = 0;
      mAwait = 1;
    end else if (mAwait && upValid && upType == 2'b10) begin
      mRev = int'(upPayload);
      mAwait = 0;
    end
  endtask

  task automatic compareAll();
    int expType, expPay, expRd;
    expType = !mSync ? 0 : (mPollNow ? 1 : 2);
    expPay  = (expType == 0) ? 0 : (expType == 1 ? int'(POLL_CODE) : int'(txData));
    expRd   = (rdAddr == REV_ADDR) ? (mRev << 4) : 0;
    chk("syncFlag", int'(syncFlag), int'(mSync));
    chk("dnType", int'(dnType), expType);
    chk("dnPayload", int'(dnPayload), expPay);
    chk("revField", int'(revField), mRev);
    chk("rdData", int'(rdData), expRd);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic sendUp(input logic [1:0] t, input logic [3:0] p);
    upValid = 1'b1; upType = t; upPayload = p;
    cyc();
    upValid = 1'b0; upType = 2'b00; upPayload = 4'h0;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      txData = txData + 8'h13;
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    rdAddr = REV_ADDR;
    @(negedge clk);
    compareAll();
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();

    // R2: idle while unsynchronized; R7: replies and rx data before sync ignored
    curReq = "R2";
    idleCycles(3);
    curReq = "R7";
    sendUp(2'b10, 4'hC);
    sendUp(2'b11, 4'h7);
    upValid = 1'b0; upType = 2'b01;   // status type without valid
    cyc();
    upType = 2'b00;
    curReq = "R3";
    chk("no sync without valid", int'(syncFlag), 0);

    // R3/R4: sync with poll enabled
    pollEnable = 1'b1;
    txData = 8'h5A;
    sendUp(2'b01, 4'h0);
    curReq = "R4";
    chk("poll frame type", int'(dnType), 1);
    chk("poll payload", int'(dnPayload), int'(POLL_CODE));
    idleCycles(4);
    chk("data frame type", int'(dnType), 2);

    // R12: toggling enable mid-episode has no effect
    curReq = "R12";
    pollEnable = 1'b0;
    idleCycles(2);

    // R6/R11: first reply loads the field; read 0x1D returns 1100 in [7:4]
    curReq = "R6";
    sendUp(2'b10, 4'hC);
    chk("rev after reply", int'(revField), 12);
    curReq = "R11";
    chk("read rev reg", int'(rdData), 8'hC0);
    rdAddr = 8'h05;
    cyc();
    chk("read other reg", int'(rdData), 0);
    rdAddr = REV_ADDR;

    // R7: later replies ignored; R8: further status frames do not re-poll
    curReq = "R7";
    sendUp(2'b10, 4'h3);
    sendUp(2'b11, 4'h9);
    curReq = "R8";
    pollEnable = 1'b1;
    sendUp(2'b01, 4'h0);
    sendUp(2'b01, 4'h0);
    idleCycles(3);
    chk("no repoll", int'(dnType), 2);

    // R9: loss wins over status in the same cycle
    curReq = "R9";
    linkLost = 1'b1;
    sendUp(2'b01, 4'h0);
    linkLost = 1'b0;
    chk("sync cleared", int'(syncFlag), 0);
    chk("rev cleared", int'(revField), 0);
    idleCycles(2);

    // R10: resync yields a new poll and new reply
    curReq = "R10";
    sendUp(2'b01, 4'h0);
    chk("new poll", int'(dnType), 1);
    sendUp(2'b10, 4'h5);   // during poll cycle: ignored
    sendUp(2'b10, 4'hC);
    chk("rev reloaded", int'(revField), 12);

    // R5: sync with enable off - no poll, field stays zero
    curReq = "R5";
    linkLost = 1'b1;
    cyc();
    linkLost = 1'b0;
    pollEnable = 1'b0;
    sendUp(2'b01, 4'h0);
    chk("data first", int'(dnType), 2);
    sendUp(2'b10, 4'hC);
    idleCycles(2);
    chk("rev stays zero", int'(revField), 0);

    // R1: reset mid-episode
    curReq = "R1";
    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    idleCycles(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule